// File: doc/BRIEF.md
# Packed Single-Precision Maximum/Minimum Unit

This block takes two packed vectors of IEEE-754 binary32 values and returns, lane by lane, either the larger or the smaller element of each pair. Every 32-bit lane works on its own. A width select picks the full 128-bit form, with four lanes, or the 64-bit form, with two lanes. In the 64-bit form the upper half of the result reads as zero.

NaN inputs follow one of two policies. The policy comes from bit 25 of a 32-bit floating-point control word. With that bit set, any NaN operand in a lane produces the canonical quiet NaN. With it clear, the NaN operand passes through, made quiet. Signed zeros are ordered strictly, so -0.0 is below +0.0. Infinities order as the extreme values.

The result and its valid flag are registered and appear on the clock edge after the input strobe.

Top module: `fpmm_unit`

## Requirements
- R1: In wide mode (`wide`=1) lane i occupies bits [32i+31:32i] of each operand and of the result, and lanes 0..3 are computed independently of one another.
- R2: In narrow mode (`wide`=0) lanes 0 and 1 are computed as in R1, and result bits [127:64] are zero.
- R3: `op_min`=0 selects the maximum and `op_min`=1 the minimum. Ordinary values are ordered numerically, e.g. max(-16.0, -15.5) = 0xC1780000 and min(-16.0, -14.5) = 0xC1800000.
- R4: Signed zeros are ordered with -0.0 (0x80000000) below +0.0 (0x00000000). Either operand order gives max = 0x00000000 and min = 0x80000000.
- R5: Infinities order as extremes: max(1.0, +inf) = 0x7F800000, max(-inf, 1.0) = 0x3F800000, min(1.0, +inf) = 0x3F800000, min(-inf, 1.0) = 0xFF800000.
- R6: When bit 25 of `ctrl_word` is 1 and either operand of a lane is a NaN (exponent all ones, fraction non-zero), the lane result is 0x7FC00000.
- R7: When bit 25 of `ctrl_word` is 0 and a lane holds a NaN, the result is that NaN with bit 22 forced to 1 (e.g. 0xFFC00000 against 1.0 gives 0xFFC00000, and 0x7F800001 gives 0x7FC00001). If both operands are NaN, operand A's NaN is used.
- R8: Only bit 25 of `ctrl_word` affects the result. Every other bit, bit 24 included, has no effect.
- R9: `out_valid` and `result` update on the rising edge after a cycle with `in_valid`=1. `out_valid` is 0 after a cycle with `in_valid`=0, and `result` then holds its last value.
- R10: A synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| wide | input | 1 | 1: four lanes (128 bits), 0: two lanes (64 bits) |
| op_min | input | 1 | 0: maximum, 1: minimum |
| ctrl_word | input | 32 | Floating-point control word; bit 25 selects the canonical-NaN policy |
| opa | input | 128 | Operand vector A |
| opb | input | 128 | Operand vector B |
| out_valid | output | 1 | Result is valid |
| result | output | 128 | Per-lane maximum or minimum |

## Verification
The assertions assume that every control input is a defined 0 or 1 whenever `in_valid` is high. They also assume that `rst` is held high for at least one edge before checking starts, so each property only looks back across cycles after reset. The stimulus sets every input at the falling edge, keeps `in_valid` low while reset is high, and sends only fully defined operand words. These words mix ordinary values, both zeros, both infinities, and quiet and signalling NaNs of either sign, under both width modes and under control words that do and do not set bit 25.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

    localparam int unsigned ELEM_W    = 32;
    localparam int unsigned EXP_W     = 8;
    localparam int unsigned FRAC_W    = 23;
    localparam int unsigned DNAN_BIT  = 25;
    localparam int unsigned QUIET_BIT = 22;
    localparam logic [ELEM_W-1:0] CANON_QNAN = 32'h7FC0_0000;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  expo;
        logic [FRAC_W-1:0] frac;
    } fp32_t;

    typedef enum logic {
        SEL_MAX = 1'b0,
        SEL_MIN = 1'b1
    } sel_e;

    typedef enum logic {
        NAN_PASS  = 1'b0,
        NAN_CANON = 1'b1
    } nan_pol_e;

    // Exponent all ones with a non-zero fraction.
    function automatic logic f_is_nan(input fp32_t x);
        return (x.expo == '1) && (x.frac != '0);
    endfunction

    // Sets the quiet bit of a NaN and keeps its sign and payload.
    function automatic fp32_t f_quiet(input fp32_t x);
        fp32_t q;
        q = x;
        q.frac[QUIET_BIT] = 1'b1;
        return q;
    endfunction

    // Strict sign-magnitude ordering of two non-NaN values; -0 is below +0.
    function automatic logic f_below(input fp32_t a, input fp32_t b);
        logic [ELEM_W-2:0] ma;
        logic [ELEM_W-2:0] mb;
        ma = {a.expo, a.frac};
        mb = {b.expo, b.frac};
        if (a.sign != b.sign)
            return a.sign;
        else if (a.sign)
            return ma > mb;
        else
            return ma < mb;
    endfunction

endpackage

// File: rtl/fpmm_lane.sv
module fpmm_lane
    import fpmm_pkg::*;
(
    input  logic       en,
    input  sel_e       sel,
    input  nan_pol_e   pol,
    input  fp32_t      a,
    input  fp32_t      b,
    output fp32_t      y
);
    logic  a_nan;
    logic  b_nan;
    logic  a_low;
    fp32_t nan_out;
    fp32_t ord_out;

    always_comb begin
        a_nan = f_is_nan(a);
        b_nan = f_is_nan(b);
        a_low = f_below(a, b);
    end

    // NaN path: canonical value, or operand A's NaN ahead of B's.
    always_comb begin
        if (pol == NAN_CANON)
            nan_out = fp32_t'(CANON_QNAN);
        else if (a_nan)
            nan_out = f_quiet(a);
        else
            nan_out = f_quiet(b);
    end

    // Ordered path.
    always_comb begin
        unique case (sel)
            SEL_MAX: ord_out = a_low ? b : a;
            SEL_MIN: ord_out = a_low ? a : b;
            default: ord_out = a;
        endcase
    end

    always_comb begin
        if (!en)
            y = '0;
        else if (a_nan || b_nan)
            y = nan_out;
        else
            y = ord_out;
    end

endmodule

// File: rtl/fpmm_lane_array.sv
module fpmm_lane_array
    import fpmm_pkg::*;
#(
    parameter int unsigned LANES = 4
)(
    input  logic                    wide,
    input  sel_e                    sel,
    input  nan_pol_e                pol,
    input  logic [LANES*ELEM_W-1:0] va,
    input  logic [LANES*ELEM_W-1:0] vb,
    output logic [LANES*ELEM_W-1:0] vy
);
    localparam int unsigned NARROW_LANES = (LANES > 1) ? LANES / 2 : 1;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic  lane_en;
        fp32_t ly;

        if (g < NARROW_LANES) begin : g_low
            assign lane_en = 1'b1;
        end else begin : g_high
            assign lane_en = wide;
        end

        fpmm_lane u_lane (
            .en  (lane_en),
            .sel (sel),
            .pol (pol),
            .a   (fp32_t'(va[g*ELEM_W +: ELEM_W])),
            .b   (fp32_t'(vb[g*ELEM_W +: ELEM_W])),
            .y   (ly)
        );

        assign vy[g*ELEM_W +: ELEM_W] = ly;
    end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
    import fpmm_pkg::*;
#(
    parameter int unsigned LANES = 4
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    wide,
    input  logic                    op_min,
    input  logic [31:0]             ctrl_word,
    input  logic [LANES*ELEM_W-1:0] opa,
    input  logic [LANES*ELEM_W-1:0] opb,
    output logic                    out_valid,
    output logic [LANES*ELEM_W-1:0] result
);
    localparam int unsigned VEC_W = LANES * ELEM_W;

    sel_e             sel;
    nan_pol_e         pol;
    logic [VEC_W-1:0] lanes_y;

    always_comb begin
        sel = op_min ? SEL_MIN : SEL_MAX;
        pol = ctrl_word[DNAN_BIT] ? NAN_CANON : NAN_PASS;
    end

    fpmm_lane_array #(.LANES(LANES)) u_array (
        .wide (wide),
        .sel  (sel),
        .pol  (pol),
        .va   (opa),
        .vb   (opb),
        .vy   (lanes_y)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid)
                result <= lanes_y;
        end
    end

endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk
    import fpmm_pkg::*;
#(
    parameter int unsigned LANES = 4
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    in_valid,
    input logic                    wide,
    input logic                    op_min,
    input logic [31:0]             ctrl_word,
    input logic [LANES*ELEM_W-1:0] opa,
    input logic [LANES*ELEM_W-1:0] opb,
    input logic                    out_valid,
    input logic [LANES*ELEM_W-1:0] result
);
    localparam int unsigned HALF = LANES * ELEM_W / 2;

    function automatic logic only_canon_nans(input logic [LANES*ELEM_W-1:0] v);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i < LANES; i++)
            if (f_is_nan(fp32_t'(v[i*ELEM_W +: ELEM_W])) &&
                v[i*ELEM_W +: ELEM_W] != CANON_QNAN)
                ok = 1'b0;
        return ok;
    endfunction

    // R9: a strobe produces a valid result on the next edge.
    p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R9: an idle cycle gives no valid and leaves the result unchanged.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R2: narrow requests leave the upper half zero.
    p_narrow_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !wide) |=> (result[LANES*ELEM_W-1:HALF] == '0));

    // R6: under the canonical policy, no other NaN pattern appears.
    p_canon_only_r6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctrl_word[DNAN_BIT]) |=> only_canon_nans(result));

    // R10: reset leaves the output idle and cleared.
    p_reset_clear_r10: assert property (@(posedge clk)
        rst |=> (!out_valid && result == '0));

endmodule

bind fpmm_unit fpmm_unit_chk #(.LANES(LANES)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .wide      (wide),
    .op_min    (op_min),
    .ctrl_word (ctrl_word),
    .opa       (opa),
    .opb       (opb),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/fpmm_unit_test.sv
module fpmm_unit_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic         wide = 1'b1;
    logic         op_min = 1'b0;
    logic [31:0]  ctrl_word = '0;
    logic [127:0] opa = '0;
    logic [127:0] opb = '0;
    logic         out_valid;
    logic [127:0] result;

    int n_cmp = 0;
    int n_bad = 0;
    logic [127:0] exp_q[$];
    string        tag_q[$];
    logic [127:0] last_exp = '0;
    logic [31:0]  lfsr = 32'h1234_5678;

    always #5 clk = ~clk;

    fpmm_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .wide(wide),
        .op_min(op_min), .ctrl_word(ctrl_word), .opa(opa), .opb(opb),
        .out_valid(out_valid), .result(result)
    );

    // Reference model: order via a monotonic unsigned key.
    function automatic logic [31:0] ref_lane(input logic [31:0] a, input logic [31:0] b,
                                             input logic mn, input logic dn);
        logic an, bn;
        logic [31:0] ka, kb;
        an = (a[30:23] == 8'hFF) && (a[22:0] != 0);
        bn = (b[30:23] == 8'hFF) && (b[22:0] != 0);
        if (an || bn) begin
            if (dn) return 32'h7FC0_0000;
            return an ? (a | 32'h0040_0000) : (b | 32'h0040_0000);
        end
        ka = a[31] ? ~a : (a | 32'h8000_0000);
        kb = b[31] ? ~b : (b | 32'h8000_0000);
        if (mn) return (ka <= kb) ? a : b;
        return (ka >= kb) ? a : b;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic send(input string req, input logic w, input logic mn, input logic [31:0] cw,
                        input logic [127:0] a, input logic [127:0] b);
        logic [127:0] e;
        e = '0;
        for (int i = 0; i < 4; i++)
            if (w || i < 2)
                e[i*32 +: 32] = ref_lane(a[i*32 +: 32], b[i*32 +: 32], mn, cw[25]);
        @(negedge clk);
        in_valid = 1'b1; wide = w; op_min = mn; ctrl_word = cw; opa = a; opb = b;
        exp_q.push_back(e);
        tag_q.push_back(req);
        last_exp = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [127:0] dup4(input logic [31:0] x);
        return {x, x, x, x};
    endfunction

    function automatic logic [31:0] pick(input logic [31:0] r);
        case (r[3:0])
            4'd0: return 32'h0000_0000;
            4'd1: return 32'h8000_0000;
            4'd2: return 32'h7F80_0000;
            4'd3: return 32'hFF80_0000;
            4'd4: return 32'h7FC0_0000;
            4'd5: return 32'hFFC0_0000;
            4'd6: return 32'h7F80_0001;
            4'd7: return 32'hFFA0_0100;
            4'd8: return 32'h3F80_0000;
            default: return r;
        endcase
    endfunction

    function automatic logic [31:0] step(input logic [31:0] s);
        return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction

    // Monitor: pops the scoreboard as results appear.
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R9: actual out_valid 1 expected 0 (no pending item)");
            end else begin
                check(tag_q.pop_front(), result, exp_q.pop_front());
            end
        end
    end

    initial begin
        #2_000_000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", {127'b0, out_valid}, '0);
        check("R10 reset", result, '0);
        rst = 1'b0;

        // R3 ordinary ordering, lanes differ (R1)
        send("R3 max", 1, 0, 32'h0, {32'hC180_0000, 32'h3F80_0000, 32'h4000_0000, 32'hC180_0000},
                                    {32'hC178_0000, 32'h4000_0000, 32'h3F80_0000, 32'hC178_0000});
        send("R3 min", 1, 1, 32'h0, dup4(32'hC180_0000), dup4(32'hC168_0000));
        send("R1 lanes", 1, 1, 32'h0, {32'h4120_0000, 32'hC120_0000, 32'h0000_0001, 32'h8000_0001},
                                      {32'hC120_0000, 32'h4120_0000, 32'h8000_0001, 32'h0000_0001});
        // R4 signed zeros
        send("R4 max +0,-0", 1, 0, 32'h0, dup4(32'h0000_0000), dup4(32'h8000_0000));
        send("R4 max -0,+0", 1, 0, 32'h0, dup4(32'h8000_0000), dup4(32'h0000_0000));
        send("R4 min +0,-0", 1, 1, 32'h0, dup4(32'h0000_0000), dup4(32'h8000_0000));
        send("R4 min -0,+0", 1, 1, 32'h0, dup4(32'h8000_0000), dup4(32'h0000_0000));
        // R5 infinities
        send("R5 max inf", 1, 0, 32'h0, dup4(32'h3F80_0000), dup4(32'h7F80_0000));
        send("R5 max -inf", 1, 0, 32'h0, dup4(32'hFF80_0000), dup4(32'h3F80_0000));
        send("R5 min inf", 1, 1, 32'h0, dup4(32'h3F80_0000), dup4(32'h7F80_0000));
        send("R5 min -inf", 1, 1, 32'h0, dup4(32'hFF80_0000), dup4(32'h3F80_0000));
        // R6 canonical NaN
        send("R6 dn nan b", 1, 0, 32'h0200_0000, dup4(32'h3F80_0000), dup4(32'h7FC0_0000));
        send("R6 dn -nan a", 1, 1, 32'h0200_0000, dup4(32'hFFC0_0000), dup4(32'h3F80_0000));
        // R7 propagation
        send("R7 -nan pass", 1, 0, 32'h0, dup4(32'hFFC0_0000), dup4(32'h3F80_0000));
        send("R7 snan quiet", 1, 1, 32'h0, dup4(32'h3F80_0000), dup4(32'h7F80_0001));
        send("R7 a first", 1, 0, 32'h0, dup4(32'hFF80_0123), dup4(32'h7FC0_0456));
        // R8 other control bits
        send("R8 bit24", 1, 0, 32'h0100_0000, dup4(32'hFFC0_0000), dup4(32'h3F80_0000));
        send("R8 others", 1, 1, 32'hFDFF_FFFF, dup4(32'h7F80_0001), dup4(32'h3F80_0000));
        send("R8 bit25 only", 1, 1, 32'h0200_0000, dup4(32'h7F80_0001), dup4(32'h3F80_0000));
        // R2 narrow mode
        send("R2 narrow", 0, 0, 32'h0, dup4(32'hC180_0000), dup4(32'hC178_0000));
        send("R2 narrow nan", 0, 1, 32'h0200_0000, dup4(32'h7FC0_0000), dup4(32'h3F80_0000));

        // R9 hold across idle cycles while inputs change
        idle(1);
        @(negedge clk);
        opa = dup4(32'h4000_0000); opb = dup4(32'hC000_0000); wide = 1'b1;
        @(negedge clk);
        check("R9 hold", result, last_exp);
        check("R9 idle valid", {127'b0, out_valid}, '0);

        // Mixed back-to-back traffic
        for (int k = 0; k < 300; k++) begin
            logic [127:0] a, b;
            logic [31:0] cw;
            for (int i = 0; i < 4; i++) begin
                lfsr = step(lfsr); a[i*32 +: 32] = pick(lfsr);
                lfsr = step(lfsr); b[i*32 +: 32] = pick(lfsr);
            end
            lfsr = step(lfsr); cw = lfsr;
            send("R1 mixed", lfsr[3], lfsr[7], cw, a, b);
            if (lfsr[11:9] == 3'd0) idle(1);
        end
        idle(3);
        check("R9 drained", {96'b0, 32'(exp_q.size())}, '0);

        // R10 reset after traffic
        send("R3 pre-reset", 1, 0, 32'h0, dup4(32'h3F80_0000), dup4(32'h4000_0000));
        @(negedge clk);
        in_valid = 1'b0;
        exp_q.delete(); tag_q.delete();
        rst = 1'b1;
        @(negedge clk);
        check("R10 rerun", {127'b0, out_valid}, '0);
        check("R10 rerun", result, '0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule